// File: doc/BRIEF.md
# Shared Bus Register Datapath

This block is the register-transfer core of a small accumulator machine. A single 16-bit bus links a 4096-word, 16-bit memory to a set of working registers: a 12-bit address register, a 12-bit program counter, and 16-bit data, accumulator, instruction and temporary registers. An 8-bit output register also hangs off the bus. Each cycle a 3-bit source code chooses the one source that drives the bus. The memory word addressed by the address register is one of those sources.

Each register has its own per-cycle strobes for load, increment and clear. An external sequencer drives the source code, the strobes and the memory read and write controls. The block exposes every register and the live bus value. The accumulator never loads directly from the bus. It takes its next value from an external arithmetic port, which the surrounding logic forms from the data register, the accumulator and input data.

Top module: `bus_datapath`

## Requirements
- R1: While rst_ni is low, every register reads zero, and this does not wait for a clock edge.
- R2: The bus carries 0 when sel_i is 0. It carries the address register for 1, the program counter for 2, the data register for 3, the accumulator for 4, the instruction register for 5 and the temporary register for 6. A 12-bit source appears zero-extended.
- R3: With sel_i at 7, the bus carries the memory word at the address held in the address register if mem_rd_i is 1, and 0 if mem_rd_i is 0.
- R4: If clear is asserted on a register, the register becomes 0 at the next rising edge, whatever its load and increment strobes are.
- R5: If load is asserted and clear is not, the address, program-counter, data and temporary registers take the bus value at the next edge, and load wins over increment. The 12-bit registers take bus bits 11..0.
- R6: If increment alone is asserted, a register adds one at the next edge and wraps to 0 from all ones: 0xFFF for the 12-bit registers, 0xFFFF for the 16-bit ones.
- R7: The instruction register changes only on its load strobe, when it takes the full bus. The output register loads bus bits 7..0 on its strobe.
- R8: The accumulator's load strobe takes alu_i, not the bus. Its clear and increment strobes behave as in R4 and R6.
- R9: If mem_wr_i is 1 at a rising edge, the bus value is stored at the address the address register held before that edge. A change to the address register in the same cycle does not move the write.
- R10: A register whose strobes are all low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Bus source code |
| ar_ld_i | input | 1 | Address register load |
| ar_inr_i | input | 1 | Address register increment |
| ar_clr_i | input | 1 | Address register clear |
| pc_ld_i | input | 1 | Program counter load |
| pc_inr_i | input | 1 | Program counter increment |
| pc_clr_i | input | 1 | Program counter clear |
| dr_ld_i | input | 1 | Data register load |
| dr_inr_i | input | 1 | Data register increment |
| dr_clr_i | input | 1 | Data register clear |
| ac_ld_i | input | 1 | Accumulator load from alu_i |
| ac_inr_i | input | 1 | Accumulator increment |
| ac_clr_i | input | 1 | Accumulator clear |
| tr_ld_i | input | 1 | Temporary register load |
| tr_inr_i | input | 1 | Temporary register increment |
| tr_clr_i | input | 1 | Temporary register clear |
| ir_ld_i | input | 1 | Instruction register load |
| outr_ld_i | input | 1 | Output register load |
| mem_rd_i | input | 1 | Memory read enable for bus source 7 |
| mem_wr_i | input | 1 | Memory write of the bus value |
| alu_i | input | 16 | Next accumulator value from the arithmetic port |
| ar_o | output | 12 | Address register |
| pc_o | output | 12 | Program counter |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| tr_o | output | 16 | Temporary register |
| outr_o | output | 8 | Output register |
| bus_o | output | 16 | Current bus value |

## Verification
The overlap of interest is a memory write and an address-register update in the same cycle. The write has to land at the old address while the address register increments, loads or clears. The bench provokes this by filling all of memory with writes that each step the address register in the same cycle. A directed case writes a known word while incrementing, then reloads the old address and reads it back through source 7. Random cycles mix write and address strobes freely. A reference model in the bench tracks memory by the pre-edge address, and the bus value of every cycle is compared against that model.

// File: rtl/bus_dp_pkg.sv
package bus_dp_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  typedef struct packed {
    logic clr;
    logic ld;
    logic inr;
  } reg_ctl_t;
endpackage

// File: rtl/dp_reg.sv
module dp_reg
  import bus_dp_pkg::*;
#(
  parameter int W       = 16,
  parameter bit HAS_CLR = 1'b1,
  parameter bit HAS_INR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  reg_ctl_t     ctl_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  logic clr_eff, inr_eff;
  assign clr_eff = ctl_i.clr & HAS_CLR;
  assign inr_eff = ctl_i.inr & HAS_INR;

  // clear > load > increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= '0;
    else if (clr_eff)    q_o <= '0;
    else if (ctl_i.ld)   q_o <= ld_val_i;
    else if (inr_eff)    q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int AW = 12,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // asynchronous read: word is on the bus in the selecting cycle
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/dp_bus_mux.sv
module dp_bus_mux
  import bus_dp_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic [2:0]    sel_i,
  input  logic [AW-1:0] ar_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] dr_i,
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] ir_i,
  input  logic [DW-1:0] tr_i,
  input  logic          mem_rd_i,
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] bus_o
);
  localparam int PAD = DW - AW;

  bus_src_e src;
  assign src = bus_src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_AR:  bus_o = {{PAD{1'b0}}, ar_i};
      SRC_PC:  bus_o = {{PAD{1'b0}}, pc_i};
      SRC_DR:  bus_o = dr_i;
      SRC_AC:  bus_o = ac_i;
      SRC_IR:  bus_o = ir_i;
      SRC_TR:  bus_o = tr_i;
      SRC_MEM: bus_o = mem_rd_i ? mem_i : '0;
      default: bus_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import bus_dp_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int OW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    sel_i,
  input  logic          ar_ld_i,
  input  logic          ar_inr_i,
  input  logic          ar_clr_i,
  input  logic          pc_ld_i,
  input  logic          pc_inr_i,
  input  logic          pc_clr_i,
  input  logic          dr_ld_i,
  input  logic          dr_inr_i,
  input  logic          dr_clr_i,
  input  logic          ac_ld_i,
  input  logic          ac_inr_i,
  input  logic          ac_clr_i,
  input  logic          tr_ld_i,
  input  logic          tr_inr_i,
  input  logic          tr_clr_i,
  input  logic          ir_ld_i,
  input  logic          outr_ld_i,
  input  logic          mem_rd_i,
  input  logic          mem_wr_i,
  input  logic [DW-1:0] alu_i,
  output logic [AW-1:0] ar_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] dr_o,
  output logic [DW-1:0] ac_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] tr_o,
  output logic [OW-1:0] outr_o,
  output logic [DW-1:0] bus_o
);
  logic [DW-1:0] bus, mem_word;

  reg_ctl_t ar_ctl, pc_ctl, dr_ctl, ac_ctl, tr_ctl, ir_ctl, outr_ctl;
  assign ar_ctl   = '{clr: ar_clr_i, ld: ar_ld_i, inr: ar_inr_i};
  assign pc_ctl   = '{clr: pc_clr_i, ld: pc_ld_i, inr: pc_inr_i};
  assign dr_ctl   = '{clr: dr_clr_i, ld: dr_ld_i, inr: dr_inr_i};
  assign ac_ctl   = '{clr: ac_clr_i, ld: ac_ld_i, inr: ac_inr_i};
  assign tr_ctl   = '{clr: tr_clr_i, ld: tr_ld_i, inr: tr_inr_i};
  assign ir_ctl   = '{clr: 1'b0, ld: ir_ld_i, inr: 1'b0};
  assign outr_ctl = '{clr: 1'b0, ld: outr_ld_i, inr: 1'b0};

  dp_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .sel_i(sel_i), .ar_i(ar_o), .pc_i(pc_o), .dr_i(dr_o), .ac_i(ac_o),
    .ir_i(ir_o), .tr_i(tr_o), .mem_rd_i(mem_rd_i), .mem_i(mem_word),
    .bus_o(bus)
  );

  dp_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i(clk_i), .we_i(mem_wr_i), .addr_i(ar_o), .wdata_i(bus),
    .rdata_o(mem_word)
  );

  dp_reg #(.W(AW)) u_ar (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ar_ctl), .ld_val_i(bus[AW-1:0]), .q_o(ar_o));
  dp_reg #(.W(AW)) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(pc_ctl), .ld_val_i(bus[AW-1:0]), .q_o(pc_o));
  dp_reg #(.W(DW)) u_dr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(dr_ctl), .ld_val_i(bus), .q_o(dr_o));
  dp_reg #(.W(DW)) u_tr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(tr_ctl), .ld_val_i(bus), .q_o(tr_o));
  // accumulator loads from the arithmetic port, not the bus
  dp_reg #(.W(DW)) u_ac (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ac_ctl), .ld_val_i(alu_i), .q_o(ac_o));
  dp_reg #(.W(DW), .HAS_CLR(1'b0), .HAS_INR(1'b0)) u_ir (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ir_ctl), .ld_val_i(bus), .q_o(ir_o));
  dp_reg #(.W(OW), .HAS_CLR(1'b0), .HAS_INR(1'b0)) u_outr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(outr_ctl), .ld_val_i(bus[OW-1:0]), .q_o(outr_o));

  assign bus_o = bus;
endmodule

// File: rtl/bus_datapath_chk.sv
module bus_datapath_chk #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int OW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    sel_i,
  input logic          ar_ld_i,
  input logic          ar_inr_i,
  input logic          ar_clr_i,
  input logic          pc_ld_i,
  input logic          pc_inr_i,
  input logic          pc_clr_i,
  input logic          dr_ld_i,
  input logic          dr_inr_i,
  input logic          dr_clr_i,
  input logic          ac_ld_i,
  input logic          ac_inr_i,
  input logic          ac_clr_i,
  input logic          tr_ld_i,
  input logic          tr_inr_i,
  input logic          tr_clr_i,
  input logic          ir_ld_i,
  input logic          outr_ld_i,
  input logic          mem_rd_i,
  input logic          mem_wr_i,
  input logic [DW-1:0] alu_i,
  input logic [AW-1:0] ar_o,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] dr_o,
  input logic [DW-1:0] ac_o,
  input logic [DW-1:0] ir_o,
  input logic [DW-1:0] tr_o,
  input logic [OW-1:0] outr_o,
  input logic [DW-1:0] bus_o
);
  AST_RESET_CLEARS: assert property (@(posedge clk_i) !rst_ni |-> (ar_o == '0 && ac_o == '0)); // R1
  AST_AR_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'd1 |-> bus_o == {{(DW-AW){1'b0}}, ar_o}); // R2
  AST_MEM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd7 && !mem_rd_i) |-> bus_o == '0); // R3
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_clr_i |=> ar_o == '0); // R4
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_ld_i && !pc_clr_i) |=> pc_o == $past(bus_o[AW-1:0])); // R5
  AST_DR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_inr_i && !dr_ld_i && !dr_clr_i) |=> dr_o == $past(dr_o) + 1'b1); // R6
  AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_ld_i |=> $stable(ir_o)); // R7
  AST_AC_FROM_ALU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ac_ld_i && !ac_clr_i) |=> ac_o == $past(alu_i)); // R8
  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd7 && mem_rd_i && $past(mem_wr_i) && ar_o == $past(ar_o))
      |-> bus_o == $past(bus_o)); // R9
  AST_TR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tr_ld_i && !tr_inr_i && !tr_clr_i) |=> $stable(tr_o)); // R10
endmodule

bind bus_datapath bus_datapath_chk #(.AW(AW), .DW(DW), .OW(OW)) u_chk (.*);

// File: tb/bus_datapath_tb.sv
`timescale 1ns/1ps
module bus_datapath_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] sel;
  logic ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr, dr_ld, dr_inr, dr_clr;
  logic ac_ld, ac_inr, ac_clr, tr_ld, tr_inr, tr_clr, ir_ld, outr_ld, mem_rd, mem_wr;
  logic [15:0] alu;
  logic [11:0] ar_o, pc_o;
  logic [15:0] dr_o, ac_o, ir_o, tr_o, bus_o;
  logic [7:0]  outr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] m_ar, m_pc;
  logic [15:0] m_dr, m_ac, m_ir, m_tr;
  logic [7:0]  m_outr;
  logic [15:0] m_mem [4096];

  always #4 clk = ~clk;

  bus_datapath u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel),
    .ar_ld_i(ar_ld), .ar_inr_i(ar_inr), .ar_clr_i(ar_clr),
    .pc_ld_i(pc_ld), .pc_inr_i(pc_inr), .pc_clr_i(pc_clr),
    .dr_ld_i(dr_ld), .dr_inr_i(dr_inr), .dr_clr_i(dr_clr),
    .ac_ld_i(ac_ld), .ac_inr_i(ac_inr), .ac_clr_i(ac_clr),
    .tr_ld_i(tr_ld), .tr_inr_i(tr_inr), .tr_clr_i(tr_clr),
    .ir_ld_i(ir_ld), .outr_ld_i(outr_ld), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .alu_i(alu), .ar_o(ar_o), .pc_o(pc_o), .dr_o(dr_o), .ac_o(ac_o),
    .ir_o(ir_o), .tr_o(tr_o), .outr_o(outr_o), .bus_o(bus_o)
  );

  function automatic logic [15:0] exp_bus();
    case (sel)
      3'd1: return {4'h0, m_ar};
      3'd2: return {4'h0, m_pc};
      3'd3: return m_dr;
      3'd4: return m_ac;
      3'd5: return m_ir;
      3'd6: return m_tr;
      3'd7: return mem_rd ? m_mem[m_ar] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  // clear > load > increment, wrap modulo width
  function automatic logic [15:0] nxt(logic [15:0] cur, logic clr, logic ld,
                                      logic inr, logic [15:0] v, logic [15:0] mask);
    if (clr) return 16'h0;
    if (ld)  return v & mask;
    if (inr) return (cur + 16'h1) & mask;
    return cur;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    sel = 3'd0; alu = 16'h0;
    {ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr, dr_ld, dr_inr, dr_clr} = '0;
    {ac_ld, ac_inr, ac_clr, tr_ld, tr_inr, tr_clr, ir_ld, outr_ld, mem_rd, mem_wr} = '0;
  endtask

  task automatic check_regs(string tag);
    chk(tag, "ar", {4'h0, ar_o}, {4'h0, m_ar});
    chk(tag, "pc", {4'h0, pc_o}, {4'h0, m_pc});
    chk(tag, "dr", dr_o, m_dr);
    chk(tag, "ac", ac_o, m_ac);
    chk(tag, "ir", ir_o, m_ir);
    chk(tag, "tr", tr_o, m_tr);
    chk(tag, "outr", {8'h0, outr_o}, {8'h0, m_outr});
  endtask

  // inputs already driven after a negedge; check bus, clock, check registers
  task automatic step(string tag);
    logic [15:0] b;
    #1;
    b = exp_bus();
    chk(tag, "bus", bus_o, b);
    @(posedge clk);
    if (mem_wr) m_mem[m_ar] = b;  // R9: old address
    m_ar   = 12'(nxt({4'h0, m_ar}, ar_clr, ar_ld, ar_inr, b, 16'h0FFF));
    m_pc   = 12'(nxt({4'h0, m_pc}, pc_clr, pc_ld, pc_inr, b, 16'h0FFF));
    m_dr   = nxt(m_dr, dr_clr, dr_ld, dr_inr, b, 16'hFFFF);
    m_tr   = nxt(m_tr, tr_clr, tr_ld, tr_inr, b, 16'hFFFF);
    m_ac   = nxt(m_ac, ac_clr, ac_ld, ac_inr, alu, 16'hFFFF);
    m_ir   = nxt(m_ir, 1'b0, ir_ld, 1'b0, b, 16'hFFFF);
    m_outr = 8'(nxt({8'h0, m_outr}, 1'b0, outr_ld, 1'b0, b, 16'h00FF));
    @(negedge clk);
    check_regs(tag);
    idle();
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    m_ar = '0; m_pc = '0; m_dr = '0; m_ac = '0; m_ir = '0; m_tr = '0; m_outr = '0;
    for (int i = 0; i < 4096; i++) m_mem[i] = 16'h0;
    // R1: reset holds everything at zero, no edge needed
    ar_ld = 1'b1; ac_ld = 1'b1; alu = 16'h1234;
    repeat (3) @(negedge clk);
    check_regs("R1");
    idle();
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: fill memory with zero, writing while AR increments
    for (int i = 0; i < 4096; i++) begin
      sel = 3'd0; mem_wr = 1'b1; ar_inr = 1'b1;
      step("R9");
    end

    // R6/R10: TR up to 3, others hold
    for (int i = 0; i < 3; i++) begin tr_inr = 1'b1; step("R6"); end
    step("R10");
    sel = 3'd6; ar_ld = 1'b1; step("R5");                 // AR = 3
    alu = 16'hFFFF; ac_ld = 1'b1; step("R8");             // AC = FFFF
    sel = 3'd4; dr_ld = 1'b1; pc_ld = 1'b1; step("R5");   // DR FFFF, PC FFF
    dr_inr = 1'b1; pc_inr = 1'b1; step("R6");             // both wrap to 0
    sel = 3'd4; ar_clr = 1'b1; ar_ld = 1'b1; ar_inr = 1'b1;
    tr_ld = 1'b1; tr_inr = 1'b1; step("R4");              // AR 0, TR load wins
    sel = 3'd0; tr_clr = 1'b1; step("R4");
    tr_inr = 1'b1; step("R6");
    tr_inr = 1'b1; step("R6");
    tr_inr = 1'b1; step("R6");                            // TR = 3
    sel = 3'd6; ar_ld = 1'b1; step("R5");                 // AR = 3
    alu = 16'hABCD; ac_ld = 1'b1; sel = 3'd1; step("R8");
    sel = 3'd4; mem_wr = 1'b1; ar_inr = 1'b1; step("R9"); // M[3]=ABCD, AR=4
    sel = 3'd7; mem_rd = 1'b1; step("R3");                // M[4] = 0
    sel = 3'd6; ar_ld = 1'b1; step("R5");                 // AR = 3
    sel = 3'd7; mem_rd = 1'b1; ir_ld = 1'b1; outr_ld = 1'b1; step("R7");
    sel = 3'd7; mem_rd = 1'b0; dr_ld = 1'b1; step("R3");  // bus 0
    sel = 3'd0; pc_ld = 1'b1; ac_inr = 1'b1; step("R2");
    sel = 3'd3; ir_ld = 1'b0; step("R7");                 // IR holds
    ac_clr = 1'b1; ac_ld = 1'b1; alu = 16'h5555; step("R8");

    // R10 and all others: random mix
    for (int n = 0; n < 3000; n++) begin
      sel = 3'($urandom % 8);
      alu = 16'($urandom);
      {ar_ld, ar_inr, ar_clr} = {$urandom%4 == 0, $urandom%3 == 0, $urandom%8 == 0};
      {pc_ld, pc_inr, pc_clr} = {$urandom%4 == 0, $urandom%3 == 0, $urandom%8 == 0};
      {dr_ld, dr_inr, dr_clr} = {$urandom%4 == 0, $urandom%3 == 0, $urandom%8 == 0};
      {ac_ld, ac_inr, ac_clr} = {$urandom%4 == 0, $urandom%3 == 0, $urandom%8 == 0};
      {tr_ld, tr_inr, tr_clr} = {$urandom%4 == 0, $urandom%3 == 0, $urandom%8 == 0};
      ir_ld = ($urandom % 4 == 0); outr_ld = ($urandom % 4 == 0);
      mem_rd = ($urandom % 4 != 0); mem_wr = ($urandom % 5 == 0);
      step("R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule